// File: doc/BRIEF.md
# Input Capture and Event Counter Front End

This block sits at the input side of a timer subsystem. It holds the 8-bit external port value and updates it from new external values presented with a strobe. Only the writable bits take the new value. Every update is compared bit by bit with the stored value. Changes on bits 0 to 2 go to three capture channels, each with its own edge selection. A change on bit 7 goes to an event counter that counts edges of one programmable polarity.

Each qualifying capture edge sets a sticky flag and sends out a one-cycle strobe with the channel number. This strobe is what makes the surrounding timer latch its free-running count. When the event counter wraps, a sticky overflow flag is set. Either kind of event also gives a one-cycle request that tells the interrupt logic to re-evaluate what is pending. Software clears flags by writing ones.

All outputs are registered. The effect of an update shows on the outputs in the cycle after the strobe.

Top module: `tef_top`

## Requirements
- R1: In the cycle after `pin_upd`, `port_q` holds the merged value. When `b7_dir` is 1, only bits 0 and 1 take `pin_val` (mask 0x03). When `b7_dir` is 0, bits 0, 1 and 7 take it (mask 0x83). All other bits keep their stored value.
- R2: `acc_count` advances by one on a bit-7 change only while `acc_en` is 1 and `acc_gated` is 0. Otherwise it holds.
- R3: With `acc_rise` = 1 the counter advances when bit 7 goes 0 to 1. With `acc_rise` = 0 it advances when bit 7 goes 1 to 0.
- R4: An increment from 0xFF to 0x00 sets `acc_ovf`. The flag stays set until it is cleared.
- R5: Channel bit i (i = 0, 1, 2) uses `edge_ctl[2i+1:2i]`. Code 00 captures nothing, 01 captures a rising edge, 10 a falling edge, and 11 either edge.
- R6: A qualifying edge on bit i sets `cap_flags[i]`. The flag stays set until it is cleared.
- R7: `cap_stb` is high for the one cycle after any capture. `cap_chan` then equals 3 - i, where i is the lowest captured bit. `cap_chan` is 0 whenever `cap_stb` is low.
- R8: `irq_eval` is high for the one cycle after any capture or counter wrap, and low otherwise.
- R9: A 1 in `cflag_clr[i]` clears `cap_flags[i]`, and `ovf_clr` clears `acc_ovf`. If a clear and a set of the same flag happen in the same cycle, the flag ends up set.
- R10: An update that changes no stored bit, or a cycle without `pin_upd`, produces no capture, count, strobe or request.
- R11: After synchronous reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_upd | input | 1 | New external port value is valid |
| pin_val | input | 8 | New external port value |
| b7_dir | input | 1 | Bit 7 driven internally (not externally writable) |
| acc_en | input | 1 | Event counter enable |
| acc_gated | input | 1 | Gated-time mode selected (suppresses counting) |
| acc_rise | input | 1 | Count rising (1) or falling (0) bit-7 edges |
| edge_ctl | input | 6 | Two-bit edge select per capture channel |
| cflag_clr | input | 3 | Write-one-to-clear for capture flags |
| ovf_clr | input | 1 | Write-one-to-clear for overflow flag |
| port_q | output | 8 | Stored port value |
| cap_flags | output | 3 | Sticky capture flags, bit i for port bit i |
| acc_ovf | output | 1 | Sticky counter overflow flag |
| acc_count | output | 8 | Event count |
| cap_stb | output | 1 | Capture strobe |
| cap_chan | output | 2 | Channel number carried by the strobe |
| irq_eval | output | 1 | Request to re-evaluate pending interrupts |

## Verification
The bench runs a seeded random mix of port values, edge codes, polarities and clear strobes. This mix makes sure the edge-code decode, the polarity choice and the flag clear-versus-set rule are each exercised against the others.

Directed runs cover the remaining corners:
- Full-port writes under both direction settings, which separate the two write masks.
- Repeated identical writes, which show that edges come from the stored value and not from the raw input.
- A gated and a disabled counter toggled on bit 7.
- A long bit-7 toggle train that crosses 0xFF, which pins down exactly when the overflow occurs.
- Simultaneous edges on bits 0 and 1, which fix which channel the strobe reports.

// File: rtl/tef_pkg.sv
package tef_pkg;

    localparam int PORT_W  = 8;
    localparam int NUM_CAP = 3;
    localparam int ACC_BIT = 7;
    localparam int CNT_W   = 8;
    localparam int CHAN_W  = $clog2(NUM_CAP + 1);

    // writable-bit masks, chosen by the bit-7 direction control
    localparam logic [PORT_W-1:0] WMASK_B7_OUT = 8'h03;
    localparam logic [PORT_W-1:0] WMASK_B7_IN  = 8'h83;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    function automatic logic [PORT_W-1:0] write_mask(input logic b7_out);
        return b7_out ? WMASK_B7_OUT : WMASK_B7_IN;
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input pin_edge_t e);
        logic h;
        case (sel)
            EDGE_RISE: h = e.rise;
            EDGE_FALL: h = e.fall;
            EDGE_ANY:  h = e.rise | e.fall;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

    // lowest captured bit wins; bit i is reported as NUM_CAP - i
    function automatic logic [CHAN_W-1:0] chan_code(input logic [NUM_CAP-1:0] hit);
        logic [CHAN_W-1:0] c;
        c = '0;
        for (int i = NUM_CAP - 1; i >= 0; i--) begin
            if (hit[i]) c = CHAN_W'(NUM_CAP - i);
        end
        return c;
    endfunction

endpackage

// File: rtl/tef_port_merge.sv
module tef_port_merge
    import tef_pkg::*;
#(
    parameter int W     = PORT_W,
    parameter int NCAP  = NUM_CAP,
    parameter int ABIT  = ACC_BIT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  upd,
    input  logic [W-1:0]          val,
    input  logic                  b7_out,
    output logic [W-1:0]          port_q,
    output pin_edge_t [NCAP-1:0]  cap_edge,
    output pin_edge_t             acc_edge
);

    logic [W-1:0] mask;
    logic [W-1:0] nxt;

    always_comb begin
        mask = write_mask(b7_out);
        nxt  = port_q;
        if (upd) nxt = (val & mask) | (port_q & ~mask);
    end

    always_ff @(posedge clk) begin
        if (rst) port_q <= '0;
        else     port_q <= nxt;
    end

    for (genvar g = 0; g < NCAP; g++) begin : g_cap_edge
        assign cap_edge[g].rise =  nxt[g] & ~port_q[g];
        assign cap_edge[g].fall = ~nxt[g] &  port_q[g];
    end

    assign acc_edge.rise =  nxt[ABIT] & ~port_q[ABIT];
    assign acc_edge.fall = ~nxt[ABIT] &  port_q[ABIT];

    localparam logic [W-1:0] FIXED_BITS = ~(WMASK_B7_OUT | WMASK_B7_IN);

    AST_FIXED_BITS_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((port_q & FIXED_BITS) == ($past(port_q) & FIXED_BITS))) // R1
        else $error("never-writable port bits changed");

    AST_IDLE_HOLDS_PORT: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(port_q)) // R10
        else $error("port changed without an update");

endmodule

// File: rtl/tef_capture_bank.sv
module tef_capture_bank
    import tef_pkg::*;
#(
    parameter int NCAP = NUM_CAP,
    parameter int CW   = CHAN_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  pin_edge_t [NCAP-1:0]  cap_edge,
    input  logic [2*NCAP-1:0]     edge_ctl,
    input  logic [NCAP-1:0]       flag_clr,
    output logic [NCAP-1:0]       flags_q,
    output logic                  stb_q,
    output logic [CW-1:0]         chan_q
);

    logic [NCAP-1:0] hit;

    for (genvar g = 0; g < NCAP; g++) begin : g_chan
        edge_sel_e sel;
        assign sel    = edge_sel_e'(edge_ctl[2*g +: 2]);
        assign hit[g] = edge_hit(sel, cap_edge[g]);

        // set dominates a simultaneous clear
        always_ff @(posedge clk) begin
            if (rst)                flags_q[g] <= 1'b0;
            else if (hit[g])        flags_q[g] <= 1'b1;
            else if (flag_clr[g])   flags_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q  <= 1'b0;
            chan_q <= '0;
        end else begin
            stb_q  <= |hit;
            chan_q <= chan_code(hit);
        end
    end

    AST_STB_MATCHES_FLAG: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> ((chan_q != '0) && flags_q[NCAP - int'(chan_q)])) // R7
        else $error("capture strobe without matching flag");

    AST_CHAN_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !stb_q |-> (chan_q == '0)) // R7
        else $error("channel number present without strobe");

endmodule

// File: rtl/tef_event_count.sv
module tef_event_count
    import tef_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_edge_t     acc_edge,
    input  logic          en,
    input  logic          gated,
    input  logic          rise_pol,
    input  logic          ovf_clr,
    output logic [CW-1:0] cnt_q,
    output logic          ovf_q,
    output logic          wrap
);

    logic inc;

    assign inc  = en & ~gated & (rise_pol ? acc_edge.rise : acc_edge.fall);
    assign wrap = inc & (&cnt_q);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (inc)    cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (wrap)    ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    AST_COUNT_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1)) // R2
        else $error("event count moved by other than one");

    AST_SUPPRESSED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en || gated) |=> $stable(cnt_q)) // R2
        else $error("count advanced while disabled or gated");

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> ((cnt_q == '0) && ($past(cnt_q) == '1))) // R4
        else $error("overflow flag rose without a wrap");

endmodule

// File: rtl/tef_top.sv
module tef_top
    import tef_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_upd,
    input  logic [PORT_W-1:0]   pin_val,
    input  logic                b7_dir,
    input  logic                acc_en,
    input  logic                acc_gated,
    input  logic                acc_rise,
    input  logic [2*NUM_CAP-1:0] edge_ctl,
    input  logic [NUM_CAP-1:0]  cflag_clr,
    input  logic                ovf_clr,
    output logic [PORT_W-1:0]   port_q,
    output logic [NUM_CAP-1:0]  cap_flags,
    output logic                acc_ovf,
    output logic [CNT_W-1:0]    acc_count,
    output logic                cap_stb,
    output logic [CHAN_W-1:0]   cap_chan,
    output logic                irq_eval
);

    pin_edge_t [NUM_CAP-1:0] cap_edge;
    pin_edge_t               acc_edge;
    logic                    wrap;
    logic                    any_hit;

    tef_port_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .upd      (pin_upd),
        .val      (pin_val),
        .b7_out   (b7_dir),
        .port_q   (port_q),
        .cap_edge (cap_edge),
        .acc_edge (acc_edge)
    );

    tef_capture_bank u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_edge (cap_edge),
        .edge_ctl (edge_ctl),
        .flag_clr (cflag_clr),
        .flags_q  (cap_flags),
        .stb_q    (cap_stb),
        .chan_q   (cap_chan)
    );

    tef_event_count u_cnt (
        .clk      (clk),
        .rst      (rst),
        .acc_edge (acc_edge),
        .en       (acc_en),
        .gated    (acc_gated),
        .rise_pol (acc_rise),
        .ovf_clr  (ovf_clr),
        .cnt_q    (acc_count),
        .ovf_q    (acc_ovf),
        .wrap     (wrap)
    );

    // capture decision, recomputed here for the request path
    always_comb begin
        any_hit = 1'b0;
        for (int i = 0; i < NUM_CAP; i++)
            any_hit |= edge_hit(edge_sel_e'(edge_ctl[2*i +: 2]), cap_edge[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_eval <= 1'b0;
        else     irq_eval <= any_hit | wrap;
    end

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (irq_eval && !cap_stb) |-> (acc_ovf && (acc_count == '0))) // R8
        else $error("interrupt request without capture or wrap");

    AST_STB_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
        cap_stb |-> irq_eval) // R8
        else $error("capture without interrupt request");

endmodule

// File: tb/sim_tef_top.sv
`timescale 1ns/1ps
module sim_tef_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       pin_upd;
    logic [7:0] pin_val;
    logic       b7_dir, acc_en, acc_gated, acc_rise;
    logic [5:0] edge_ctl;
    logic [2:0] cflag_clr;
    logic       ovf_clr;
    logic [7:0] port_q;
    logic [2:0] cap_flags;
    logic       acc_ovf;
    logic [7:0] acc_count;
    logic       cap_stb;
    logic [1:0] cap_chan;
    logic       irq_eval;

    always #2 clk = ~clk;

    tef_top u0 (
        .clk(clk), .rst(rst), .pin_upd(pin_upd), .pin_val(pin_val),
        .b7_dir(b7_dir), .acc_en(acc_en), .acc_gated(acc_gated),
        .acc_rise(acc_rise), .edge_ctl(edge_ctl), .cflag_clr(cflag_clr),
        .ovf_clr(ovf_clr), .port_q(port_q), .cap_flags(cap_flags),
        .acc_ovf(acc_ovf), .acc_count(acc_count), .cap_stb(cap_stb),
        .cap_chan(cap_chan), .irq_eval(irq_eval)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model state
    logic [7:0] m_port, m_cnt;
    logic [2:0] m_flags;
    logic       m_ovf;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic cap_q(input logic [1:0] code, input logic r, input logic f);
        case (code)
            2'b01:   return r;
            2'b10:   return f;
            2'b11:   return r | f;
            default: return 1'b0;
        endcase
    endfunction

    // drive one cycle at a negedge, compute expectation, sample at next negedge
    task automatic step(input logic upd, input logic [7:0] val, input logic dir,
                        input logic en, input logic gtd, input logic pol,
                        input logic [5:0] ectl, input logic [2:0] fclr, input logic oclr);
        logic [7:0] mask, mrg, dlt;
        logic [2:0] hit;
        logic       inc, wrp, e_stb;
        logic [1:0] e_chan;
        pin_upd = upd; pin_val = val; b7_dir = dir; acc_en = en; acc_gated = gtd;
        acc_rise = pol; edge_ctl = ectl; cflag_clr = fclr; ovf_clr = oclr;
        mask = dir ? 8'h03 : 8'h83;                       // R1
        mrg  = upd ? ((val & mask) | (m_port & ~mask)) : m_port;
        dlt  = mrg ^ m_port;
        for (int i = 0; i < 3; i++)                        // R5
            hit[i] = cap_q(ectl[2*i +: 2], dlt[i] & mrg[i], dlt[i] & ~mrg[i]);
        inc  = en && !gtd && dlt[7] && (pol ? mrg[7] : !mrg[7]); // R2 R3
        wrp  = inc && (m_cnt == 8'hFF);                    // R4
        e_stb  = |hit;
        e_chan = hit[0] ? 2'd3 : hit[1] ? 2'd2 : hit[2] ? 2'd1 : 2'd0;
        m_port  = mrg;
        m_cnt   = m_cnt + {7'd0, inc};
        m_flags = (m_flags & ~fclr) | hit;                 // R9
        m_ovf   = (m_ovf & ~oclr) | wrp;
        @(posedge clk);
        @(negedge clk);
        check("R1 port_q", port_q, m_port);
        check("R2/R3 acc_count", acc_count, m_cnt);
        check("R4/R9 acc_ovf", acc_ovf, m_ovf);
        check("R6/R9 cap_flags", cap_flags, m_flags);
        check("R7 cap_stb", cap_stb, e_stb);
        check("R7 cap_chan", cap_chan, e_chan);
        check("R8 irq_eval", irq_eval, e_stb | wrp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        void'($urandom(32'd5150));
        rst = 1'b1; pin_upd = 0; pin_val = 0; b7_dir = 0; acc_en = 0;
        acc_gated = 0; acc_rise = 0; edge_ctl = 0; cflag_clr = 0; ovf_clr = 0;
        m_port = 0; m_cnt = 0; m_flags = 0; m_ovf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 port_q", port_q, 0);
        check("R11 flags", cap_flags, 0);
        check("R11 count", acc_count, 0);
        check("R11 ovf/stb/req", {acc_ovf, cap_stb, irq_eval, cap_chan}, 0);

        // R1: masks under both direction settings
        step(1, 8'hFF, 1, 0, 0, 0, 6'h00, 0, 0);
        check("R1 dir=1 mask", port_q, 8'h03);
        step(1, 8'hFF, 0, 0, 0, 0, 6'h00, 0, 0);
        check("R1 dir=0 mask", port_q, 8'h83);
        step(1, 8'h00, 0, 0, 0, 0, 6'h00, 0, 0);

        // R10: identical writes produce no events
        step(1, 8'h00, 0, 1, 0, 1, 6'h3F, 0, 0);
        check("R10 no-change strobe", cap_stb, 0);
        step(0, 8'hFF, 0, 1, 0, 1, 6'h3F, 0, 0);
        check("R10 idle no-change", port_q, 8'h00);

        // R2: gated or disabled counter holds
        for (int k = 0; k < 8; k++) step(1, {k[0], 7'd0}, 0, 1, 1, 1, 6'h00, 0, 0);
        for (int k = 0; k < 8; k++) step(1, {~k[0], 7'd0}, 0, 0, 0, 0, 6'h00, 0, 0);
        check("R2 suppressed count", acc_count, 0);

        // R3/R4: falling count then rising train across 0xFF
        for (int k = 0; k < 20; k++) step(1, {k[0], 7'd0}, 0, 1, 0, 0, 6'h00, 0, 0);
        for (int k = 0; k < 520; k++) step(1, {k[0], 7'd0}, 0, 1, 0, 1, 6'h00, 0, 0);
        check("R4 overflow seen", acc_ovf, 1);
        step(0, 8'h00, 0, 1, 0, 1, 6'h00, 3'b000, 1);
        check("R9 ovf cleared", acc_ovf, 0);

        // R7: simultaneous edges on bits 0 and 1, lowest wins
        step(1, 8'h00, 0, 0, 0, 0, 6'h00, 3'b111, 0);
        step(1, 8'h03, 0, 0, 0, 0, 6'h3F, 0, 0);
        check("R7 priority chan", cap_chan, 3);
        // R5: falling-only on bit 1, rising-only on bit 0
        step(1, 8'h00, 0, 0, 0, 0, 6'b00_10_01, 3'b111, 0);
        check("R5 falling only", cap_flags, 3'b010);
        // R9: clear coinciding with a set keeps the flag
        step(1, 8'h01, 0, 0, 0, 0, 6'b00_00_01, 3'b111, 0);
        check("R9 set wins", cap_flags, 3'b001);

        // seeded random mix
        for (int k = 0; k < 6000; k++) begin
            v = 8'($urandom);
            step(($urandom % 4) != 0, v, 1'($urandom % 2), ($urandom % 8) != 0,
                 ($urandom % 8) == 0, 1'($urandom % 2), 6'($urandom),
                 (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
                 ($urandom % 16) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule